// File: doc/BRIEF.md
# Encoded Arithmetic and Logic Unit

This block performs the arithmetic and logic instruction class of a small processor. It takes a 4-bit function code and two 32-bit operands. The first operand always comes from a register. The second comes either from a register or from an 8-bit immediate that is zero-extended. The result is combinational, so it is valid in the same cycle as the inputs.

A single registered zero flag goes with the result, and conditional branches read it. The flag changes only on a clock edge where flag update is requested and the function code is defined. At all other edges it keeps its last value. A compare is therefore a flag-setting subtract, and the branch that follows tests the flag.

Function codes with the top bit clear, and the two unassigned codes in the upper half, give a zero result and never disturb the flag.

Top module: `enc_alu`

## Requirements
- R1: Function code 4'b1000 drives `result` with the sum of the two operands, modulo 2^32, in the same cycle.
- R2: Function code 4'b1001 drives `result` with the first operand minus the second operand, modulo 2^32.
- R3: Function codes 4'b1010, 4'b1011 and 4'b1100 drive `result` with the bitwise AND, OR and XOR of the operands, in that order.
- R4: Function code 4'b1101 drives `result` to zero whatever the operands are. With flag update enabled, the next edge sets the zero flag.
- R5: When `use_imm` is 1, the second operand is `imm` zero-extended to 32 bits and `op_b_reg` has no effect. When `use_imm` is 0, the second operand is `op_b_reg`.
- R6: On a rising clock edge where `flag_en` is 1 and the function code is defined (codes 4'b1000 to 4'b1101), `zero_flag` takes 1 if `result` was all zeros and 0 otherwise.
- R7: On a rising clock edge where `flag_en` is 0, `zero_flag` keeps its value.
- R8: Undefined function codes (top bit 0, or 4'b1110 or 4'b1111) drive `result` to zero. They leave `zero_flag` unchanged, even when `flag_en` is 1.
- R9: While `rst_n` is low, `zero_flag` is 0. The reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the zero flag updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| func | input | 4 | Function code |
| op_a | input | 32 | First operand, from a register |
| op_b_reg | input | 32 | Second operand when taken from a register |
| imm | input | 8 | Immediate, zero-extended when selected |
| use_imm | input | 1 | 1 selects the immediate as the second operand |
| flag_en | input | 1 | Flag update enable for this operation |
| result | output | 32 | Combinational operation result |
| zero_flag | output | 1 | Registered zero flag |

## Verification
In every cycle the block presents the result of the current operation and the flag left by an earlier one. The bench checks these together: at each step it samples `result` combinationally, just after driving the inputs. It then samples `zero_flag` just after the following edge and compares it with a model flag. That model flag is updated only under the R6 conditions.

The stimulus mixes several cases in a single stream: flag-setting operations, operations with the flag disabled, and undefined codes with `flag_en` high. Operand pairs are biased so that zero results occur often. A flag that tracks the wrong cycle, or that updates when it should not, therefore shows up as a mismatch.

// File: rtl/enc_alu_pkg.sv
package enc_alu_pkg;

    localparam int FUNC_W = 4;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_ADD = 3'b000,
        SEL_SUB = 3'b001,
        SEL_AND = 3'b010,
        SEL_OR  = 3'b011,
        SEL_XOR = 3'b100,
        SEL_CLR = 3'b101
    } alu_sel_e;

    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] sel;
    } alu_dec_t;

    function automatic alu_dec_t decode_func(input logic [FUNC_W-1:0] f);
        alu_dec_t d;
        d.sel   = f[SEL_W-1:0];
        d.valid = f[FUNC_W-1] && (f[SEL_W-1:0] <= SEL_CLR);
        return d;
    endfunction

endpackage

// File: rtl/enc_alu_decode.sv
module enc_alu_decode
    import enc_alu_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output alu_dec_t          dec
);
    always_comb begin
        dec = decode_func(func);
    end
endmodule

// File: rtl/enc_alu_opmux.sv
module enc_alu_opmux #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic [DATA_W-1:0] op_b_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    output logic [DATA_W-1:0] op_b
);
    localparam int PAD_W = DATA_W - IMM_W;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                op_b = use_imm ? {{PAD_W{1'b0}}, imm} : op_b_reg;
            end
        end else begin : g_nopad
            always_comb begin
                op_b = use_imm ? imm[DATA_W-1:0] : op_b_reg;
            end
        end
    endgenerate
endmodule

// File: rtl/enc_alu_core.sv
module enc_alu_core
    import enc_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_dec_t          dec,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result
);
    logic              is_sub;
    logic [DATA_W-1:0] b_adj;
    logic [DATA_W-1:0] sum;

    always_comb begin
        is_sub = (dec.sel == SEL_SUB);
        b_adj  = b ^ {DATA_W{is_sub}};
        sum    = a + b_adj + {{(DATA_W-1){1'b0}}, is_sub};
    end

    always_comb begin
        result = '0;
        if (dec.valid) begin
            case (alu_sel_e'(dec.sel))
                SEL_ADD, SEL_SUB: result = sum;
                SEL_AND:          result = a & b;
                SEL_OR:           result = a | b;
                SEL_XOR:          result = a ^ b;
                default:          result = '0;
            endcase
        end
    end
endmodule

// File: rtl/enc_alu_flag.sv
module enc_alu_flag #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              update,
    input  logic [DATA_W-1:0] result,
    output logic              zero
);
    typedef struct packed {
        logic zero;
    } flag_state_t;

    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (update) begin
            state_d.zero = ~|result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign zero = state_q.zero;
endmodule

// File: rtl/enc_alu.sv
module enc_alu
    import enc_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        func,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              flag_en,
    output logic [DATA_W-1:0] result,
    output logic              zero_flag
);
    alu_dec_t          dec;
    logic [DATA_W-1:0] op_b;
    logic              flag_upd;

    enc_alu_decode u_dec (
        .func (func),
        .dec  (dec)
    );

    enc_alu_opmux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_mux (
        .op_b_reg (op_b_reg),
        .imm      (imm),
        .use_imm  (use_imm),
        .op_b     (op_b)
    );

    enc_alu_core #(.DATA_W(DATA_W)) u_core (
        .dec    (dec),
        .a      (op_a),
        .b      (op_b),
        .result (result)
    );

    assign flag_upd = flag_en && dec.valid;

    enc_alu_flag #(.DATA_W(DATA_W)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .update (flag_upd),
        .result (result),
        .zero   (zero_flag)
    );
endmodule

// File: rtl/enc_alu_chk.sv
module enc_alu_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        func,
    input logic [DATA_W-1:0] op_a,
    input logic [IMM_W-1:0]  imm,
    input logic              use_imm,
    input logic              flag_en,
    input logic [DATA_W-1:0] result,
    input logic              zero_flag
);
    logic undef_code;
    assign undef_code = !func[3] || (func[2:1] == 2'b11);

    a_r6_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !undef_code) |=> (zero_flag == ($past(result) == '0)));

    a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |=> $stable(zero_flag));

    a_r8_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        undef_code |-> (result == '0));

    a_r8_undef_keep: assert property (@(posedge clk) disable iff (!rst_n)
        undef_code |=> $stable(zero_flag));

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b1101) |-> (result == '0));

    a_r5_imm_add: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && func == 4'b1000) |->
            (result == op_a + {{(DATA_W-IMM_W){1'b0}}, imm}));

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r9_reset_flag: assert (zero_flag == 1'b0);
        end
    end
endmodule

bind enc_alu enc_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .func      (func),
    .op_a      (op_a),
    .imm       (imm),
    .use_imm   (use_imm),
    .flag_en   (flag_en),
    .result    (result),
    .zero_flag (zero_flag)
);

// File: tb/enc_alu_tb.sv
module enc_alu_tb;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    func;
    logic [W-1:0]  op_a, op_b_reg;
    logic [7:0]    imm;
    logic          use_imm, flag_en;
    logic [W-1:0]  result;
    logic          zero_flag;

    int checks = 0;
    int errors = 0;
    logic exp_flag;

    always #2 clk = ~clk;

    enc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .func(func), .op_a(op_a),
        .op_b_reg(op_b_reg), .imm(imm), .use_imm(use_imm),
        .flag_en(flag_en), .result(result), .zero_flag(zero_flag)
    );

    function automatic logic is_def(input logic [3:0] f);
        return f[3] && (f[2:0] <= 3'd5);
    endfunction

    function automatic logic [W-1:0] model(input logic [3:0] f,
        input logic [W-1:0] a, input logic [W-1:0] b);
        case (f)
            4'b1000: return a + b;
            4'b1001: return a - b;
            4'b1010: return a & b;
            4'b1011: return a | b;
            4'b1100: return a ^ b;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] f, input logic ui);
        if (ui) return "R5";
        case (f)
            4'b1000: return "R1";
            4'b1001: return "R2";
            4'b1010, 4'b1011, 4'b1100: return "R3";
            4'b1101: return "R4";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] f, input logic [W-1:0] a,
        input logic [W-1:0] b, input logic [7:0] im, input logic ui,
        input logic fe);
        logic [W-1:0] bsel, er;
        @(negedge clk);
        func = f; op_a = a; op_b_reg = b; imm = im; use_imm = ui; flag_en = fe;
        bsel = ui ? {24'd0, im} : b;
        er = model(f, a, bsel);
        #1;
        check(tag_of(f, ui), result, er);
        @(posedge clk);
        if (fe && is_def(f)) exp_flag = (er == '0);
        #1;
        if (!fe) check("R7", {31'd0, zero_flag}, {31'd0, exp_flag});
        else if (!is_def(f)) check("R8", {31'd0, zero_flag}, {31'd0, exp_flag});
        else check("R6", {31'd0, zero_flag}, {31'd0, exp_flag});
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; func = 4'b0; op_a = '0; op_b_reg = '0; imm = '0;
        use_imm = 1'b0; flag_en = 1'b0; exp_flag = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R9", {31'd0, zero_flag}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed cases
        step(4'b1000, 32'd5, 32'd2, 8'd0, 1'b0, 1'b1);            // R1 nonzero
        step(4'b1000, 32'hFFFF_FFFF, 32'd1, 8'd0, 1'b0, 1'b1);    // R1 wrap to zero, R6 set
        step(4'b1001, 32'd7, 32'd9, 8'd0, 1'b0, 1'b1);            // R2 negative, R6 clear
        step(4'b1001, 32'd12, 32'd12, 8'd0, 1'b0, 1'b1);          // R2 equal -> flag
        step(4'b1001, 32'd300, 32'hDEAD_BEEF, 8'd255, 1'b1, 1'b1);// R5 imm, reg ignored
        step(4'b1000, 32'h1000_0000, 32'hFFFF_FFFF, 8'h80, 1'b1, 1'b0); // R5 zero-ext, R7
        step(4'b1010, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 8'd0, 1'b0, 1'b1);  // R3 AND -> 0
        step(4'b1011, 32'hF0F0_0000, 32'h0000_0F0F, 8'd0, 1'b0, 1'b1);  // R3 OR
        step(4'b1100, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 8'd0, 1'b0, 1'b1);  // R3 XOR -> 0
        step(4'b1000, 32'd1, 32'd1, 8'd0, 1'b0, 1'b1);
        step(4'b1101, 32'hFFFF_FFFF, 32'h1234_5678, 8'd9, 1'b0, 1'b1);  // R4 clear sets flag
        step(4'b1000, 32'd4, 32'd4, 8'd0, 1'b0, 1'b0);            // R7 flag held
        step(4'b0110, 32'hFF, 32'hFF, 8'd0, 1'b0, 1'b1);          // R8 low half
        step(4'b1110, 32'd3, 32'd0, 8'd0, 1'b0, 1'b1);            // R8
        step(4'b1111, 32'd0, 32'd0, 8'd0, 1'b0, 1'b1);            // R8

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0]   f;
            logic [W-1:0] a, b;
            logic [7:0]   im;
            logic         ui, fe;
            f  = ($urandom_range(0, 9) < 8) ? {1'b1, 3'($urandom_range(0, 7))}
                                            : 4'($urandom_range(0, 15));
            a  = $urandom;
            b  = $urandom;
            im = 8'($urandom);
            ui = ($urandom_range(0, 3) == 0);
            fe = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 3) == 0) begin
                if (ui) a = {24'd0, im};
                else b = (f == 4'b1000) ? (~a + 32'd1) : a;
            end
            step(f, a, b, im, ui, fe);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule